// File: doc/BRIEF.md
# UART Receive Parity and Error Flag Unit

This block sits between a serial shift engine and the software-visible data path of one serial channel. On the transmit side it takes each byte written to the transmit holding register, computes its parity with the even/odd choice in force at that write, and places the parity bit where the frame format needs it. In the 7-bit frame format that is bit 7 of the holding register. In the 8-bit format it is a separate ninth-bit output.

On the receive side the shift engine delivers completed frames. The block checks each frame's parity, stores accepted frames in a small receive store, and raises sticky error flags. The store is a single buffer, or, when the FIFO is enabled, a queue of up to four entries with a programmable usable depth. The flags are overrun, parity (or transmit underrun in the synchronous modes), and an aggregate FIFO parity error. Reading the status clears all three flags.

Mode encoding on `cfg_mode`: 2'b00 synchronous with clock output, 2'b01 synchronous with clock input, 2'b10 UART 7-bit, 2'b11 UART 8-bit. The bit order of `stat_flags` is [0] overrun, [1] parity/underrun, [2] FIFO parity error.

Top module: `uart_err_unit`

## Requirements
- R1: After reset, `stat_flags` is 0, `rd_valid` is 0, `tx_buf` is 0 and `tx_bit9` is 0.
- R2: In UART 7-bit mode with parity enabled, a transmit write loads `tx_buf` = {p, data[6:0]}. Here p makes the count of ones in bits 7:0 even when `cfg_par_even`=1 and odd when it is 0. `tx_bit9` is 0. With parity disabled, `tx_buf` = data unchanged.
- R3: In UART 8-bit mode a transmit write loads `tx_buf` = data. With parity enabled, `tx_bit9` is the parity bit over the 8 data bits under the same even/odd rule; with parity disabled, `tx_bit9` is 0.
- R4: Parity settings are taken at the moment of the transmit write. Changing them afterwards leaves `tx_buf` and `tx_bit9` unchanged.
- R5: In UART 7-bit mode, received bit 7 is the parity bit for bits 6:0. With parity enabled, an accepted frame whose parity mismatches sets `stat_flags[1]`. With parity disabled, no parity flag is raised.
- R6: In UART 8-bit mode, `rx_bit9` is the parity bit for the 8 data bits, and a mismatch on an accepted frame with parity enabled sets `stat_flags[1]`.
- R7: In the synchronous modes, received frames are not parity-checked and `stat_flags[1]` is set by a `tx_underrun` pulse. In UART modes, `tx_underrun` has no effect.
- R8: With the FIFO disabled, a frame that completes while the buffer still holds an unread frame sets `stat_flags[0]`. The new frame is discarded and the buffered frame is kept.
- R9: With the FIFO enabled, frames are accepted until the stored count reaches the usable limit `cfg_fifo_lim` (0 treated as 1, values above 4 as 4). Only a frame beyond that limit sets overrun. Frames are read out in arrival order.
- R10: With the FIFO enabled, an accepted frame with a parity error also sets `stat_flags[2]`. With the FIFO disabled, `stat_flags[2]` is never set.
- R11: In synchronous clock-output mode, overrun is never flagged; a frame that finds no room is dropped silently.
- R12: A `stat_rd` pulse clears all flags at the next clock edge. An error event in the same cycle as the read leaves its flag set.
- R13: A frame arriving in the same cycle as a read of a full store is accepted, and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Channel mode (see encoding above) |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| cfg_fifo_en | input | 1 | Receive FIFO enable |
| cfg_fifo_lim | input | 3 | Usable FIFO depth, 1 to 4 |
| tx_wr | input | 1 | Transmit holding register write strobe |
| tx_wdata | input | 8 | Transmit write data |
| tx_underrun | input | 1 | Underrun pulse from shift engine (synchronous modes) |
| tx_buf | output | 8 | Transmit holding register |
| tx_bit9 | output | 1 | Transmit ninth bit |
| rx_done | input | 1 | Frame-complete pulse from shift engine |
| rx_data | input | 8 | Received data byte (bit 7 is parity in 7-bit mode) |
| rx_bit9 | input | 1 | Received ninth bit |
| rd_buf | input | 1 | Consumer read of receive data (pops head) |
| rd_data | output | 8 | Head of receive store |
| rd_bit9 | output | 1 | Ninth bit of head entry |
| rd_valid | output | 1 | Receive store not empty |
| stat_rd | input | 1 | Status read strobe, clears flags |
| stat_flags | output | 3 | {fifo_err, parity/underrun, overrun} |

## Verification
Two pairs of functions can coincide in one cycle. The first is a status read and a new error event. This is provoked by pulsing `stat_rd` in the same cycle as a frame that overruns the buffer, and it is judged by the overrun flag still being set afterwards. The second is a frame arriving while the consumer reads a full store. The arrival and `rd_buf` are driven together, and it is judged by no overrun being flagged and the new frame appearing at the head.

// File: rtl/uart_err_pkg.sv
package uart_err_pkg;

  typedef enum logic [1:0] {
    MODE_SYNC_CLKOUT = 2'b00,
    MODE_SYNC_CLKIN  = 2'b01,
    MODE_UART7       = 2'b10,
    MODE_UART8       = 2'b11
  } ser_mode_t;

  localparam int FLAG_OVR  = 0;
  localparam int FLAG_PAR  = 1;
  localparam int FLAG_FERR = 2;
  localparam int NFLAGS    = 3;

  // parity bit that completes the frame: over 8 bits when wide, else bits 6:0
  function automatic logic par_bit(input logic [7:0] bits, input logic wide,
                                   input logic even_sel);
    logic x;
    x = wide ? ^bits : ^bits[6:0];
    return even_sel ? x : ~x;
  endfunction

  function automatic logic is_uart(input ser_mode_t m);
    return (m == MODE_UART7) || (m == MODE_UART8);
  endfunction

endpackage

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_err_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ser_mode_t  mode,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] tx_buf,
  output logic       tx_bit9
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf  <= '0;
      tx_bit9 <= 1'b0;
    end else if (wr) begin
      tx_bit9 <= 1'b0;
      tx_buf  <= wdata;
      if (par_en && mode == MODE_UART7)
        tx_buf <= {par_bit(wdata, 1'b0, par_even), wdata[6:0]};
      if (par_en && mode == MODE_UART8)
        tx_bit9 <= par_bit(wdata, 1'b1, par_even);
    end
  end

  // R4: holding register only moves on a write
  a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(tx_buf) && $stable(tx_bit9)));

  // R2: total ones across the 8 stored bits follow the parity sense
  a_r2_tx7_total: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && par_en && mode == MODE_UART7) |=> ((^tx_buf) == !$past(par_even)));

  // R3: data plus ninth bit follow the parity sense
  a_r3_tx8_total: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && par_en && mode == MODE_UART8) |=> ((^{tx_bit9, tx_buf}) == !$past(par_even)));

endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store #(
  parameter int DEPTH = 4,
  parameter int DW    = 9,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [CW-1:0] lim,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          head_valid,
  output logic          accept,
  output logic          reject
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cap;
  logic          do_pop, room;

  function automatic logic [CW-1:0] clamp_lim(input logic [CW-1:0] l);
    if (l == '0) return CW'(1);
    if (l > CW'(DEPTH)) return CW'(DEPTH);
    return l;
  endfunction

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign cap    = fifo_en ? clamp_lim(lim) : CW'(1);
  assign do_pop = pop && (cnt != '0);
  assign room   = (cnt < cap) || do_pop;
  assign accept = push && room;
  assign reject = push && !room;
  assign head   = mem[rptr];
  assign head_valid = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (accept) wptr <= nxt(wptr);
      if (do_pop) rptr <= nxt(rptr);
      cnt <= cnt + CW'(accept) - CW'(do_pop);
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           mem[i] <= '0;
        else if (accept && wptr == PW'(i))    mem[i] <= push_data;
      end
    end
  endgenerate

  // R8: a dropped frame leaves the occupancy and the head untouched
  a_r8_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> ($stable(cnt) && $stable(head)));

  // R9: occupancy never exceeds the physical depth
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

endmodule

// File: rtl/uart_err_flags.sv
module uart_err_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] flags
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flags[i] <= 1'b0;
        else if (set[i]) flags[i] <= 1'b1;
        else if (clr)    flags[i] <= 1'b0;
      end

      // R12: an event in the read cycle survives the clear
      a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set[i] |=> flags[i]);

      // R12: read with no new event clears the flag
      a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set[i]) |=> !flags[i]);
    end
  endgenerate

endmodule

// File: rtl/uart_err_unit.sv
module uart_err_unit
  import uart_err_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  localparam int LIMW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_mode,
  input  logic            cfg_par_en,
  input  logic            cfg_par_even,
  input  logic            cfg_fifo_en,
  input  logic [LIMW-1:0] cfg_fifo_lim,
  input  logic            tx_wr,
  input  logic [7:0]      tx_wdata,
  input  logic            tx_underrun,
  output logic [7:0]      tx_buf,
  output logic            tx_bit9,
  input  logic            rx_done,
  input  logic [7:0]      rx_data,
  input  logic            rx_bit9,
  input  logic            rd_buf,
  output logic [7:0]      rd_data,
  output logic            rd_bit9,
  output logic            rd_valid,
  input  logic            stat_rd,
  output logic [2:0]      stat_flags
);

  ser_mode_t mode;
  logic      uart_m, wide, exp_par, got_par, frame_perr;
  logic      rx_accept, rx_reject;
  logic      ovr_evt, par_evt, ferr_evt;
  logic [8:0] head;
  logic [NFLAGS-1:0] set_vec;

  assign mode    = ser_mode_t'(cfg_mode);
  assign uart_m  = is_uart(mode);
  assign wide    = (mode == MODE_UART8);
  assign exp_par = par_bit(rx_data, wide, cfg_par_even);
  assign got_par = wide ? rx_bit9 : rx_data[7];
  assign frame_perr = uart_m && cfg_par_en && (exp_par != got_par);

  uart_tx_parity u_tx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .par_en(cfg_par_en),
    .par_even(cfg_par_even), .wr(tx_wr), .wdata(tx_wdata),
    .tx_buf(tx_buf), .tx_bit9(tx_bit9)
  );

  uart_rx_store #(.DEPTH(FIFO_DEPTH), .DW(9)) u_store (
    .clk(clk), .rst_n(rst_n), .fifo_en(cfg_fifo_en), .lim(cfg_fifo_lim),
    .push(rx_done), .push_data({rx_bit9, rx_data}), .pop(rd_buf),
    .head(head), .head_valid(rd_valid), .accept(rx_accept), .reject(rx_reject)
  );

  assign rd_data = head[7:0];
  assign rd_bit9 = head[8];

  // named event wires
  assign ovr_evt  = rx_reject && (mode != MODE_SYNC_CLKOUT);
  assign par_evt  = uart_m ? (rx_accept && frame_perr) : tx_underrun;
  assign ferr_evt = rx_accept && frame_perr && cfg_fifo_en;

  always_comb begin
    set_vec            = '0;
    set_vec[FLAG_OVR]  = ovr_evt;
    set_vec[FLAG_PAR]  = par_evt;
    set_vec[FLAG_FERR] = ferr_evt;
  end

  uart_err_flags #(.N(NFLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(set_vec), .clr(stat_rd), .flags(stat_flags)
  );

  // R11: in clock-output mode a status read always leaves overrun clear
  a_r11_no_ovr_clkout: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SYNC_CLKOUT && stat_rd) |=> !stat_flags[FLAG_OVR]);

  // R7: underrun in a synchronous mode raises the shared flag
  a_r7_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    (!uart_m && tx_underrun) |=> stat_flags[FLAG_PAR]);

  // R10: aggregate error never set while FIFO is disabled, after a read
  a_r10_ferr_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fifo_en && stat_rd) |=> !stat_flags[FLAG_FERR]);

  // R13: arrival with a read pending on a non-empty store is never an overrun
  a_r13_pop_room: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rd_buf && rd_valid) |-> !ovr_evt);

endmodule

// File: tb/uart_err_unit_bench.sv
module uart_err_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b10;
  logic       cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_fifo_en = 1'b0;
  logic [2:0] cfg_fifo_lim = 3'd1;
  logic       tx_wr = 1'b0, tx_underrun = 1'b0;
  logic [7:0] tx_wdata = '0;
  logic [7:0] tx_buf;
  logic       tx_bit9;
  logic       rx_done = 1'b0, rx_bit9 = 1'b0, rd_buf = 1'b0, stat_rd = 1'b0;
  logic [7:0] rx_data = '0;
  logic [7:0] rd_data;
  logic       rd_bit9, rd_valid;
  logic [2:0] stat_flags;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_err_unit u_uart_err_unit (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_fifo_en(cfg_fifo_en), .cfg_fifo_lim(cfg_fifo_lim),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_underrun(tx_underrun),
    .tx_buf(tx_buf), .tx_bit9(tx_bit9), .rx_done(rx_done), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rd_buf(rd_buf), .rd_data(rd_data), .rd_bit9(rd_bit9),
    .rd_valid(rd_valid), .stat_rd(stat_rd), .stat_flags(stat_flags)
  );

  // parity bit over the low n bits: even sense -> bit equals (ones mod 2)
  function automatic logic want_par(input logic [7:0] d, input int n, input logic even);
    int ones = 0;
    for (int i = 0; i < n; i++) ones += d[i];
    return even ? logic'(ones % 2) : logic'(1 - ones % 2);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic b9);
    rx_done = 1'b1; rx_data = d; rx_bit9 = b9;
    step();
    rx_done = 1'b0;
  endtask

  task automatic pop();
    rd_buf = 1'b1; step(); rd_buf = 1'b0;
  endtask

  task automatic rd_stat();
    stat_rd = 1'b1; step(); stat_rd = 1'b0;
  endtask

  task automatic txw(input logic [7:0] d);
    tx_wr = 1'b1; tx_wdata = d; step(); tx_wr = 1'b0;
  endtask

  task automatic cleanup();
    for (int i = 0; i < 6; i++) if (rd_valid) pop();
    rd_stat();
  endtask

  task automatic t_reset();
    chk(stat_flags, 3'b000, "R1 flags");
    chk(rd_valid, 1'b0, "R1 rd_valid");
    chk(tx_buf, 8'h00, "R1 tx_buf");
    chk(tx_bit9, 1'b0, "R1 tx_bit9");
  endtask

  task automatic t_tx7();
    logic [7:0] pats [3] = '{8'h35, 8'h7F, 8'h00};
    cfg_mode = 2'b10; cfg_par_en = 1'b1;
    for (int e = 0; e < 2; e++)
      for (int k = 0; k < 3; k++) begin
        cfg_par_even = logic'(e);
        txw(pats[k]);
        chk(tx_buf, {want_par(pats[k], 7, logic'(e)), pats[k][6:0]}, "R2 tx7 parity");
        chk(tx_bit9, 1'b0, "R2 tx7 bit9");
      end
    cfg_par_en = 1'b0;
    txw(8'hB5);
    chk(tx_buf, 8'hB5, "R2 tx7 parity off");
  endtask

  task automatic t_tx8();
    cfg_mode = 2'b11; cfg_par_en = 1'b1;
    cfg_par_even = 1'b1; txw(8'hA7);
    chk(tx_buf, 8'hA7, "R3 tx8 data");
    chk(tx_bit9, want_par(8'hA7, 8, 1'b1), "R3 tx8 even");
    cfg_par_even = 1'b0; txw(8'hA7);
    chk(tx_bit9, want_par(8'hA7, 8, 1'b0), "R3 tx8 odd");
    cfg_par_en = 1'b0; txw(8'h01);
    chk(tx_bit9, 1'b0, "R3 tx8 parity off");
  endtask

  task automatic t_latch();
    cfg_mode = 2'b10; cfg_par_en = 1'b1; cfg_par_even = 1'b1;
    txw(8'h01);
    cfg_par_even = 1'b0; step();
    cfg_par_en = 1'b0; step();
    chk(tx_buf, 8'h81, "R4 config taken at write");
    cfg_mode = 2'b11; cfg_par_en = 1'b1; cfg_par_even = 1'b0;
    txw(8'h03);
    cfg_par_even = 1'b1; step();
    chk(tx_bit9, 1'b1, "R4 ninth bit held");
  endtask

  task automatic t_rx7();
    cfg_mode = 2'b10; cfg_fifo_en = 1'b0; cfg_par_en = 1'b1; cfg_par_even = 1'b1;
    send({want_par(8'h15, 7, 1'b1), 7'h15}, 1'b0);
    chk(stat_flags[1], 1'b0, "R5 good parity");
    chk(rd_data, {want_par(8'h15, 7, 1'b1), 7'h15}, "R5 stored byte");
    pop();
    send({~want_par(8'h15, 7, 1'b1), 7'h15}, 1'b0);
    chk(stat_flags[1], 1'b1, "R5 bad parity");
    chk(stat_flags[2], 1'b0, "R10 no fifo err with fifo off");
    cleanup();
    chk(stat_flags, 3'b000, "R12 cleared by read");
    cfg_par_en = 1'b0;
    send(8'h95 ^ 8'h80, 1'b0); send(8'h00, 1'b0);
    chk(stat_flags[1], 1'b0, "R5 parity disabled");
    cleanup();
  endtask

  task automatic t_rx8();
    cfg_mode = 2'b11; cfg_par_en = 1'b1; cfg_par_even = 1'b0;
    send(8'hC3, want_par(8'hC3, 8, 1'b0));
    chk(stat_flags[1], 1'b0, "R6 good ninth bit");
    chk(rd_bit9, want_par(8'hC3, 8, 1'b0), "R6 stored ninth bit");
    pop();
    send(8'hC3, ~want_par(8'hC3, 8, 1'b0));
    chk(stat_flags[1], 1'b1, "R6 bad ninth bit");
    cleanup();
  endtask

  task automatic t_sync();
    cfg_mode = 2'b01; cfg_par_en = 1'b1; cfg_par_even = 1'b1;
    send(8'h01, 1'b0);
    chk(stat_flags[1], 1'b0, "R7 no parity check in sync");
    tx_underrun = 1'b1; step(); tx_underrun = 1'b0;
    chk(stat_flags[1], 1'b1, "R7 underrun sets flag");
    cleanup();
    cfg_mode = 2'b10;
    tx_underrun = 1'b1; step(); tx_underrun = 1'b0;
    chk(stat_flags[1], 1'b0, "R7 underrun ignored in uart");
  endtask

  task automatic t_ovr();
    cfg_mode = 2'b10; cfg_par_en = 1'b0; cfg_fifo_en = 1'b0;
    send(8'h11, 1'b0); send(8'h22, 1'b0);
    chk(stat_flags[0], 1'b1, "R8 overrun");
    chk(rd_data, 8'h11, "R8 first kept");
    pop();
    chk(rd_valid, 1'b0, "R8 second discarded");
    cleanup();
  endtask

  task automatic t_fifo();
    cfg_mode = 2'b11; cfg_par_en = 1'b0; cfg_fifo_en = 1'b1; cfg_fifo_lim = 3'd3;
    send(8'hA1, 1'b0); send(8'hA2, 1'b1); send(8'hA3, 1'b0);
    chk(stat_flags[0], 1'b0, "R9 no overrun below limit");
    send(8'hA4, 1'b0);
    chk(stat_flags[0], 1'b1, "R9 overrun at limit");
    chk(rd_data, 8'hA1, "R9 order 1"); pop();
    chk({rd_bit9, rd_data}, 9'h1A2, "R9 order 2"); pop();
    chk(rd_data, 8'hA3, "R9 order 3"); pop();
    chk(rd_valid, 1'b0, "R9 empty after three");
    cleanup();
    cfg_fifo_lim = 3'd0;
    send(8'h01, 1'b0); send(8'h02, 1'b0);
    chk(stat_flags[0], 1'b1, "R9 limit 0 acts as 1");
    cleanup();
    cfg_fifo_lim = 3'd4;
    for (int i = 0; i < 4; i++) send(8'(i), 1'b0);
    chk(stat_flags[0], 1'b0, "R9 full depth 4");
    cleanup();
  endtask

  task automatic t_ferr();
    cfg_mode = 2'b10; cfg_fifo_en = 1'b1; cfg_fifo_lim = 3'd4;
    cfg_par_en = 1'b1; cfg_par_even = 1'b1;
    send({want_par(8'h05, 7, 1'b1), 7'h05}, 1'b0);
    chk(stat_flags[2], 1'b0, "R10 clean frame");
    send({~want_par(8'h05, 7, 1'b1), 7'h05}, 1'b0);
    chk(stat_flags[2:1], 2'b11, "R10 fifo parity error");
    cleanup();
    cfg_fifo_en = 1'b0;
  endtask

  task automatic t_clkout();
    cfg_mode = 2'b00; cfg_fifo_en = 1'b0; cfg_par_en = 1'b0;
    send(8'h5A, 1'b0); send(8'h6B, 1'b0);
    chk(stat_flags[0], 1'b0, "R11 no overrun clock-out");
    chk(rd_data, 8'h5A, "R11 first kept");
    cleanup();
  endtask

  task automatic t_collide();
    cfg_mode = 2'b10; cfg_fifo_en = 1'b0; cfg_par_en = 1'b0;
    send(8'h31, 1'b0);
    rx_done = 1'b1; rx_data = 8'h32; stat_rd = 1'b1;
    step();
    rx_done = 1'b0; stat_rd = 1'b0;
    chk(stat_flags[0], 1'b1, "R12 event beats clear");
    cleanup();
    send(8'h41, 1'b0);
    rx_done = 1'b1; rx_data = 8'h42; rd_buf = 1'b1;
    step();
    rx_done = 1'b0; rd_buf = 1'b0;
    chk(stat_flags[0], 1'b0, "R13 no overrun with pop");
    chk(rd_data, 8'h42, "R13 new frame at head");
    cleanup();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_tx7();
    t_tx8();
    t_latch();
    t_rx7();
    t_rx8();
    t_sync();
    t_ovr();
    t_fifo();
    t_ferr();
    t_clkout();
    t_collide();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule